// File: doc/BRIEF.md
# Constrained Random Replacement Index Generator

This block picks a pseudo-random slot for a translation buffer that has to evict an entry. The slots below a programmable wired boundary are locked and never chosen. Each pick draws on a 32-bit right-shifting Galois LFSR. The LFSR value is reduced into the window that runs from the wired boundary up to the last slot. A pick that repeats the slot returned by the previous pick is thrown away, and the generator draws again until the slot differs.

The reduction runs in a bit-serial restoring divider, so one draw takes 33 clock cycles. The caller pulses `req` while the block is idle. It then waits for `idx_valid`, which is high for one cycle together with the chosen slot on `idx`. The slot count and wired count are captured when a request is accepted. If the window has one slot or none, the block returns the wired count on the next cycle without drawing. This avoids a search that could never end and a division by zero.

Top module: `repl_index_gen`

## Requirements
- R1: After a synchronous active-high reset, `idx_valid` is 0 and `idx` is 0. The LFSR holds 1 and the remembered previous slot is 0.
- R2: The LFSR shifts right by one on each draw. When the bit shifted out is 1, the shifted value is XORed with 0xD0000001. Exactly one step is taken per draw and none when the block returns without drawing.
- R3: Every drawn candidate equals `(lfsr mod (entry_count - wired_count)) + wired_count`, where lfsr is the freshly stepped value. A returned slot therefore lies in `[wired_count, entry_count-1]`.
- R4: A candidate equal to the previously returned slot is discarded and a new draw follows. The search repeats until the candidate differs.
- R5: When `entry_count <= wired_count + 1`, a request returns `wired_count` without any draw. This includes the case where the wired count exceeds the slot count.
- R6: `idx_valid` rises 1 cycle after an accepted request that takes no draw. It rises 33·n + 1 cycles after an accepted request that needs n draws, counting the accepting edge as cycle 1.
- R7: A `req` raised while a search is in progress is ignored. It produces no extra `idx_valid` pulse and does not step the LFSR.
- R8: Changes to `entry_count` or `wired_count` during a search do not affect its result.
- R9: The remembered previous slot is updated only with the value actually returned, including a value returned without a draw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe; accepted only when idle |
| entry_count | input | IDX_W+1 | Total number of slots (at most 2^IDX_W) |
| wired_count | input | IDX_W | Number of locked slots at the bottom of the buffer |
| idx | output | IDX_W | Returned slot, registered |
| idx_valid | output | 1 | One-cycle pulse marking a returned slot |

## Verification
The situation hardest to reach is the repeat-and-redraw path. On a wide window a candidate rarely matches the previous slot, so random traffic almost never exercises it. The stimulus table therefore includes several requests with a two-slot window, back to back, so that about half of the draws collide and need extra passes. The reference model counts the draws each request needs, and the measured latency must match 33 cycles per draw. This shows that the redraws really happen. A request with no draw that lands on a slot also used by the following wide-window request shows that such results are remembered.

// File: rtl/repl_pkg.sv
package repl_pkg;

  localparam int unsigned LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 32'h0000_0001;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'hD000_0001;

  typedef enum logic [0:0] {
    GEN_IDLE = 1'b0,
    GEN_WAIT = 1'b1
  } gen_state_t;

  // One right shift; the feedback mask is applied when a 1 falls out.
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] cur);
    lfsr_advance = (cur >> 1) ^ (cur[0] ? LFSR_TAPS : '0);
  endfunction

endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr
  import repl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [LFSR_W-1:0] nxt
);

  logic [LFSR_W-1:0] state_q;

  assign nxt = lfsr_advance(state_q);

  always_ff @(posedge clk) begin
    if (rst)      state_q <= LFSR_SEED;
    else if (adv) state_q <= nxt;
  end

  // R2: a Galois register with a nonzero seed never reaches zero
  a_r2_nonzero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R2, R7: the register moves only when a draw is launched
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state_q));

endmodule

// File: rtl/repl_modreduce.sv
module repl_modreduce #(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [VW-1:0] rem
);

  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] dq;
  logic [VW-1:0] div_q;
  logic [VW-1:0] rem_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  logic [VW:0]   trial;
  logic [VW:0]   diff;
  logic [VW-1:0] rem_n;

  // Restoring step: bring in the next dividend bit, subtract if it fits.
  always_comb begin
    trial = {rem_q, dq[DW-1]};
    diff  = trial - {1'b0, div_q};
    rem_n = (trial >= {1'b0, div_q}) ? diff[VW-1:0] : trial[VW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq     <= '0;
      div_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        dq     <= dividend;
        div_q  <= divisor;
        rem_q  <= '0;
        cnt_q  <= CW'(DW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_n;
        dq    <= dq << 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign rem  = rem_q;

  // R7: a new reduction is never launched over one in flight
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q);

  // R3: the finished remainder is below the divisor
  a_r3_rem_bound: assert property (@(posedge clk) disable iff (rst)
    done_q |-> rem_q < div_q);

  // R6: completion is a single-cycle event
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/repl_index_gen.sv
module repl_index_gen
  import repl_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W:0]   entry_count,
  input  logic [IDX_W-1:0] wired_count,
  output logic [IDX_W-1:0] idx,
  output logic             idx_valid
);

  localparam int unsigned CW = IDX_W + 1;

  gen_state_t        state_q;
  logic [CW-1:0]     span_q;
  logic [IDX_W-1:0]  wired_q;
  logic [IDX_W-1:0]  prev_q;
  logic [IDX_W-1:0]  idx_q;
  logic              valid_q;

  logic [CW-1:0]     span_in;
  logic              narrow_in;
  logic              accept;
  logic              retry;
  logic              finish;
  logic              launch;
  logic [IDX_W-1:0]  cand;
  logic [LFSR_W-1:0] lfsr_nxt;
  logic              div_busy;
  logic              div_done;
  logic [CW-1:0]     div_rem;
  logic [CW-1:0]     div_arg;

  assign span_in   = entry_count - {1'b0, wired_count};
  assign narrow_in = entry_count <= ({1'b0, wired_count} + CW'(1));
  assign accept    = (state_q == GEN_IDLE) && req;
  assign cand      = div_rem[IDX_W-1:0] + wired_q;
  assign retry     = (state_q == GEN_WAIT) && div_done && (cand == prev_q);
  assign finish    = (state_q == GEN_WAIT) && div_done && (cand != prev_q);
  assign launch    = (accept && !narrow_in) || retry;
  assign div_arg   = accept ? span_in : span_q;

  repl_lfsr u_lfsr (
    .clk (clk),
    .rst (rst),
    .adv (launch),
    .nxt (lfsr_nxt)
  );

  repl_modreduce #(.DW(LFSR_W), .VW(CW)) u_mod (
    .clk      (clk),
    .rst      (rst),
    .start    (launch),
    .dividend (lfsr_nxt),
    .divisor  (div_arg),
    .busy     (div_busy),
    .done     (div_done),
    .rem      (div_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GEN_IDLE;
      span_q  <= '0;
      wired_q <= '0;
      prev_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        GEN_IDLE: begin
          if (req) begin
            span_q  <= span_in;
            wired_q <= wired_count;
            if (narrow_in) begin
              idx_q   <= wired_count;
              prev_q  <= wired_count;
              valid_q <= 1'b1;
            end else begin
              state_q <= GEN_WAIT;
            end
          end
        end
        GEN_WAIT: begin
          if (finish) begin
            idx_q   <= cand;
            prev_q  <= cand;
            valid_q <= 1'b1;
            state_q <= GEN_IDLE;
          end
        end
        default: state_q <= GEN_IDLE;
      endcase
    end
  end

  assign idx       = idx_q;
  assign idx_valid = valid_q;

  // Checker state: kind of the last accepted request and the last output seen.
  logic             chk_narrow;
  logic [IDX_W-1:0] chk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_narrow <= 1'b0;
      chk_last   <= '0;
    end else begin
      if (accept)  chk_narrow <= narrow_in;
      if (valid_q) chk_last   <= idx_q;
    end
  end

  // R3: a drawn slot lies inside the captured window
  a_r3_window: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !chk_narrow) |->
      (idx_q >= wired_q) && (({1'b0, idx_q} - {1'b0, wired_q}) < span_q));

  // R4, R9: a drawn slot never repeats the previous output
  a_r4_differs: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !chk_narrow) |-> idx_q != chk_last);

  // R5: a narrow window returns the boundary itself
  a_r5_narrow: assert property (@(posedge clk) disable iff (rst)
    (valid_q && chk_narrow) |-> idx_q == wired_q);

  // R8: captured operands hold while a search runs
  a_r8_captured: assert property (@(posedge clk) disable iff (rst)
    (state_q == GEN_WAIT) |=> ($stable(span_q) && $stable(wired_q)));

  // R6: results only appear when no reduction is running
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> !div_busy);

endmodule

// File: tb/repl_index_gen_bench.sv
`timescale 1ns/1ps
module repl_index_gen_bench;

  localparam int unsigned IDX_W = 6;
  localparam int NV = 14;
  localparam int WATCHDOG = 150000;

  // Stimulus: {entry_count[6:0], wired_count[5:0]}
  localparam logic [12:0] VECS [NV] = '{
    {7'd64, 6'd0},  {7'd64, 6'd8},  {7'd2, 6'd0},   {7'd2, 6'd0},
    {7'd2, 6'd0},   {7'd3, 6'd1},   {7'd5, 6'd4},   {7'd16, 6'd4},
    {7'd1, 6'd0},   {7'd4, 6'd6},   {7'd64, 6'd62}, {7'd64, 6'd62},
    {7'd2, 6'd1},   {7'd10, 6'd0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req = 1'b0;
  logic [IDX_W:0]   entry_count = '0;
  logic [IDX_W-1:0] wired_count = '0;
  logic [IDX_W-1:0] idx;
  logic             idx_valid;

  int checks = 0;
  int fails  = 0;
  int cyc_total = 0;
  bit done_flag = 1'b0;

  logic [31:0] m_lfsr;
  logic [5:0]  m_prev;

  always #2.5 clk = ~clk;

  repl_index_gen #(.IDX_W(IDX_W)) u_repl_index_gen (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .entry_count (entry_count),
    .wired_count (wired_count),
    .idx         (idx),
    .idx_valid   (idx_valid)
  );

  function automatic logic [31:0] m_step(input logic [31:0] s);
    logic out_bit;
    out_bit = s[0];
    s = s >> 1;
    if (out_bit) s = s ^ 32'hD000_0001;
    return s;
  endfunction

  // Reference model from the requirements; returns slot and number of draws.
  task automatic model_pick(input int ent, input int wir, output int exp_idx, output int draws);
    int span;
    draws = 0;
    if (ent <= wir + 1) begin
      exp_idx = wir;
    end else begin
      span = ent - wir;
      do begin
        m_lfsr  = m_step(m_lfsr);
        exp_idx = int'(m_lfsr % 32'(span)) + wir;
        draws++;
      end while (exp_idx == int'(m_prev));
    end
    m_prev = 6'(exp_idx);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Issue one request and wait for the result; returns measured latency.
  task automatic issue(input int ent, input int wir, output int got, output int lat);
    @(negedge clk);
    entry_count = 7'(ent);
    wired_count = 6'(wir);
    req = 1'b1;
    lat = 0;
    got = -1;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      req = 1'b0;
      if (idx_valid) begin
        got = int'(idx);
        break;
      end
      if (lat > 3000) break;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_total++;
      if (cyc_total > WATCHDOG) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc_total, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    int exp_idx, draws, got, lat, nvalid;
    m_lfsr = 32'h1;
    m_prev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 idx after reset", int'(idx), 0);
    check("R1 valid after reset", int'(idx_valid), 0);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      int ent, wir;
      ent = int'(VECS[i][12:6]);
      wir = int'(VECS[i][5:0]);
      model_pick(ent, wir, exp_idx, draws);
      issue(ent, wir, got, lat);
      check($sformatf("R2/R3/R4/R5/R9 slot, vector %0d", i), got, exp_idx);
      check($sformatf("R6 latency, vector %0d", i), lat, (draws == 0) ? 1 : 33 * draws + 1);
    end

    // R7: requests during a search are ignored
    model_pick(64, 0, exp_idx, draws);
    @(negedge clk);
    entry_count = 7'd64;
    wired_count = 6'd0;
    req = 1'b1;
    nvalid = 0;
    got = -1;
    for (int c = 1; c <= 140; c++) begin
      @(posedge clk);
      @(negedge clk);
      req = (c >= 5 && c <= 8) ? 1'b1 : 1'b0;
      if (idx_valid) begin
        nvalid++;
        got = int'(idx);
      end
    end
    check("R7 single result despite busy requests", nvalid, 1);
    check("R7 slot unaffected", got, exp_idx);
    model_pick(20, 3, exp_idx, draws);
    issue(20, 3, got, lat);
    check("R7 LFSR not stepped by busy requests", got, exp_idx);

    // R8: operands changed mid-search have no effect
    model_pick(16, 4, exp_idx, draws);
    @(negedge clk);
    entry_count = 7'd16;
    wired_count = 6'd4;
    req = 1'b1;
    got = -1;
    for (int c = 1; c <= 200; c++) begin
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      if (c == 3) begin
        entry_count = 7'd2;
        wired_count = 6'd0;
      end
      if (idx_valid) begin
        got = int'(idx);
        break;
      end
    end
    check("R8 captured operands", got, exp_idx);

    // R1: reset in the middle of a search
    @(negedge clk);
    entry_count = 7'd64;
    wired_count = 6'd0;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 idx after mid-run reset", int'(idx), 0);
    check("R1 valid after mid-run reset", int'(idx_valid), 0);
    rst = 1'b0;
    m_lfsr = 32'h1;
    m_prev = '0;
    model_pick(64, 0, exp_idx, draws);
    issue(64, 0, got, lat);
    check("R1/R2 seed restored after reset", got, exp_idx);

    finish_run();
  end

endmodule